// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Timing Monitor

This block watches the command pins of a four-bank DDR SDRAM from the controller side. It samples them on every rising clock edge and reduces each cycle to a single command. It keeps track of which banks have an open row. It also counts the cycles since each relevant earlier command. It never drives anything toward the memory. Its outputs are a one-cycle violation pulse with a reason code, and a vector that shows the open or closed state of each bank.

It is meant to sit beside a memory controller in simulation or on silicon debug logic. It catches command streams that break an ordering rule or a minimum spacing rule before any data path is involved. All spacings are parameters given in clock cycles. The defaults suit a 6 ns clock. Of the address bus, the monitor needs only the auto-precharge/all-bank bit and the three low bits that carry the burst-length field of a mode-register write. The remaining row and column bits carry nothing that it checks.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With `cke` high and `cs_n` low, the pin pattern {`ras_n`,`cas_n`,`we_n`} decodes as follows: 011 is activate, 101 is read, 100 is write, 010 is precharge, 001 is auto refresh, 000 is mode-register write, 110 is burst stop and 111 is no-operation. A cycle with `cs_n` high is a deselect. Neither a deselect nor a no-operation ever raises a violation or changes a bank.
- R2: `ba` selects the bank as a binary number from 0 to 3. Bit b of `bank_open` is high from the cycle after an activate to bank b until that bank is closed.
- R3: A precharge closes the selected bank. When `ap_a10` is high, the precharge closes all four banks whatever `ba` holds. A read or a write with `ap_a10` high closes its bank if that bank is open.
- R4: A mode-register write, an auto refresh or a self-refresh entry issued while any bank is open gives code 4.
- R5: A read or a write to a closed bank gives code 5. An activate to a bank that is already open gives code 6.
- R6: Per bank, with k the number of cycles since the earlier command: a read or write at k below T_RCD after an activate gives code 7. A precharge of an open bank at k below T_RAS after its activate gives code 8. This includes any open bank hit by an all-bank precharge. An activate at k below T_RP after the bank was closed gives code 9. An activate at k below T_RC after the previous activate to the same bank gives code 10.
- R7: An activate at k below T_RRD after an activate to any bank gives code 11.
- R8: Any command other than no-operation or deselect gives code 1 when issued at k below T_MRD after a mode-register write. It gives code 2 when issued at k below T_RFC after an auto refresh.
- R9: A mode-register write with `ba`=0 sets the burst length from `addr_lo`: 001 sets 2 beats, 010 sets 4 beats and 011 sets 8 beats. Any other value, or a nonzero `ba`, leaves the burst length unchanged. Reset selects 4 beats. A write with auto-precharge to an open bank makes every read or write during the next burst/2 − 1 cycles a code 3 violation. An auto-precharge starts the T_RP wait only after burst/2 cycles.
- R10: A cycle with `cke` low is not decoded, and all spacing counters keep running through it. The one exception is the refresh pattern in the first cycle with `cke` low after a cycle with `cke` high, which is a self-refresh entry.
- R11: A violation appears on `viol_valid` and `viol_code` in the cycle after the command, for exactly that one cycle. When several rules break at once, the lowest code is reported. Bank state and counters update for every decoded command, including commands that violate a rule.
- R12: A synchronous active-high `rst` closes every bank, clears every counter and the violation output, and restores the 4-beat burst length. The first command after reset is checked against no earlier command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; pins sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| ap_a10 | input | 1 | Auto-precharge / all-bank address bit |
| addr_lo | input | 3 | Low address bits, burst-length field on mode writes |
| viol_valid | output | 1 | One-cycle pulse marking a rule violation |
| viol_code | output | 4 | Reason of the reported violation, 0 when none |
| bank_open | output | 2**BA_W | Open-row flag per bank |

## Verification
The assertions assume that the pins are stable and known at each rising edge, and that `cs_n` and `cke` are never X after reset. They also assume that only one command per cycle reaches the monitor, which the pin encoding guarantees. The bench changes every input only on the falling edge, always drives a defined command pattern, and holds reset for two full cycles before it issues any command. Each scripted sequence places commands exactly at a spacing limit and one cycle short of it. This shows both sides of every window, and every run starts from a reset state that the bench knows.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_SREF,
        CMD_MRS,
        CMD_BST
    } ddr_cmd_e;

    // Lower value wins when several rules break in one cycle.
    typedef enum logic [3:0] {
        V_NONE   = 4'd0,
        V_MRD    = 4'd1,
        V_RFC    = 4'd2,
        V_WAP    = 4'd3,
        V_IDLE   = 4'd4,
        V_CLOSED = 4'd5,
        V_OPEN   = 4'd6,
        V_RCD    = 4'd7,
        V_RAS    = 4'd8,
        V_RP     = 4'd9,
        V_RC     = 4'd10,
        V_RRD    = 4'd11
    } viol_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_mon_pkg::*;
(
    input  logic     cke,
    input  logic     cke_prev,
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output ddr_cmd_e cmd
);

    always_comb begin
        cmd = CMD_NONE;
        if (!cs_n) begin
            if (cke) begin
                unique case ({ras_n, cas_n, we_n})
                    3'b011:  cmd = CMD_ACT;
                    3'b101:  cmd = CMD_RD;
                    3'b100:  cmd = CMD_WR;
                    3'b010:  cmd = CMD_PRE;
                    3'b001:  cmd = CMD_REF;
                    3'b000:  cmd = CMD_MRS;
                    3'b110:  cmd = CMD_BST;
                    default: cmd = CMD_NONE;
                endcase
            end else if (cke_prev && {ras_n, cas_n, we_n} == 3'b001) begin
                cmd = CMD_SREF;
            end
        end
    end

endmodule

// File: rtl/ddr_countdown.sv
module ddr_countdown #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy
);

    typedef struct packed {
        logic [W-1:0] rem;
    } cd_t;

    cd_t cd_d, cd_q;

    always_comb begin
        cd_d = cd_q;
        if (cd_q.rem != '0) cd_d.rem = cd_q.rem - 1'b1;
        if (load)           cd_d.rem = load_val;
    end

    always_ff @(posedge clk) begin
        if (rst) cd_q <= '0;
        else     cd_q <= cd_d;
    end

    assign busy = (cd_q.rem != '0);

    // R8
    cd_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(load));

    // R10
    cd_step_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !load |=> cd_q.rem == $past(cd_q.rem) - 1'b1);

endmodule

// File: rtl/ddr_bank_state.sv
module ddr_bank_state #(
    parameter int W     = 6,
    parameter int T_RCD = 3,
    parameter int T_RAS = 7,
    parameter int T_RC  = 10,
    parameter int T_RP  = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         act,
    input  logic         pre,
    input  logic         ap,
    input  logic [W-1:0] ap_hold,
    output logic         is_open,
    output logic         rcd_busy,
    output logic         ras_busy,
    output logic         rc_busy,
    output logic         rp_busy
);

    typedef struct packed {
        logic         open;
        logic [W-1:0] rcd;
        logic [W-1:0] ras;
        logic [W-1:0] rc;
        logic [W-1:0] rp;
    } bank_t;

    bank_t bk_d, bk_q;

    function automatic logic [W-1:0] dn(input logic [W-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    always_comb begin
        bk_d     = bk_q;
        bk_d.rcd = dn(bk_q.rcd);
        bk_d.ras = dn(bk_q.ras);
        bk_d.rc  = dn(bk_q.rc);
        bk_d.rp  = dn(bk_q.rp);
        if (act) begin
            bk_d.open = 1'b1;
            bk_d.rcd  = W'(T_RCD - 1);
            bk_d.ras  = W'(T_RAS - 1);
            bk_d.rc   = W'(T_RC - 1);
        end else if (pre && bk_q.open) begin
            bk_d.open = 1'b0;
            bk_d.rp   = W'(T_RP - 1);
        end else if (ap && bk_q.open) begin
            bk_d.open = 1'b0;
            bk_d.rp   = ap_hold + W'(T_RP - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bk_q <= '0;
        else     bk_q <= bk_d;
    end

    assign is_open  = bk_q.open;
    assign rcd_busy = (bk_q.rcd != '0);
    assign ras_busy = (bk_q.ras != '0);
    assign rc_busy  = (bk_q.rc  != '0);
    assign rp_busy  = (bk_q.rp  != '0);

    // R3
    bank_close_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(is_open) |-> $past(pre || ap));

    // R2
    bank_act_chk: assert property (@(posedge clk) disable iff (rst)
        act |=> is_open && ras_busy);

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
    import ddr_mon_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RAS = 7,
    parameter int T_RRD = 2,
    parameter int T_RC  = 10,
    parameter int T_MRD = 2,
    parameter int T_RFC = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic              ap_a10,
    input  logic [2:0]        addr_lo,
    output logic              viol_valid,
    output logic [3:0]        viol_code,
    output logic [(1<<BA_W)-1:0] bank_open
);

    localparam int NB = 1 << BA_W;
    localparam int CW = $clog2(T_RCD + T_RP + T_RAS + T_RRD + T_RC + T_MRD + T_RFC + 8);

    typedef struct packed {
        logic         cke;
        viol_e        code;
        logic [CW-1:0] burst;
    } mon_t;

    mon_t st_d, st_q;

    ddr_cmd_e cmd;
    logic [NB-1:0] sel, rcd_b, ras_b, rc_b, rp_b;
    logic rrd_busy, mrd_busy, rfc_busy, wap_busy;
    logic is_rw, any_open, ras_hit;

    ddr_cmd_decode u_dec (
        .cke(cke), .cke_prev(st_q.cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
    );

    always_comb begin
        sel = '0;
        sel[ba] = 1'b1;
    end

    assign is_rw = (cmd == CMD_RD) || (cmd == CMD_WR);

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bank
            ddr_bank_state #(
                .W(CW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP)
            ) u_bank (
                .clk(clk), .rst(rst),
                .act(cmd == CMD_ACT && sel[b]),
                .pre(cmd == CMD_PRE && (ap_a10 || sel[b])),
                .ap(is_rw && ap_a10 && sel[b]),
                .ap_hold(st_q.burst),
                .is_open(bank_open[b]),
                .rcd_busy(rcd_b[b]), .ras_busy(ras_b[b]),
                .rc_busy(rc_b[b]), .rp_busy(rp_b[b])
            );
        end
    endgenerate

    ddr_countdown #(.W(CW)) u_rrd (
        .clk(clk), .rst(rst), .load(cmd == CMD_ACT),
        .load_val(CW'(T_RRD - 1)), .busy(rrd_busy)
    );
    ddr_countdown #(.W(CW)) u_mrd (
        .clk(clk), .rst(rst), .load(cmd == CMD_MRS),
        .load_val(CW'(T_MRD - 1)), .busy(mrd_busy)
    );
    ddr_countdown #(.W(CW)) u_rfc (
        .clk(clk), .rst(rst), .load(cmd == CMD_REF),
        .load_val(CW'(T_RFC - 1)), .busy(rfc_busy)
    );
    ddr_countdown #(.W(CW)) u_wap (
        .clk(clk), .rst(rst),
        .load(cmd == CMD_WR && ap_a10 && bank_open[ba]),
        .load_val(st_q.burst - 1'b1), .busy(wap_busy)
    );

    assign any_open = |bank_open;
    assign ras_hit  = ap_a10 ? |(bank_open & ras_b) : (bank_open[ba] && ras_b[ba]);

    always_comb begin
        st_d     = st_q;
        st_d.cke = cke;
        if (cmd == CMD_MRS && ba == '0) begin
            case (addr_lo)
                3'b001:  st_d.burst = CW'(1);
                3'b010:  st_d.burst = CW'(2);
                3'b011:  st_d.burst = CW'(4);
                default: st_d.burst = st_q.burst;
            endcase
        end
        if (cmd != CMD_NONE && mrd_busy)                              st_d.code = V_MRD;
        else if (cmd != CMD_NONE && rfc_busy)                         st_d.code = V_RFC;
        else if (is_rw && wap_busy)                                   st_d.code = V_WAP;
        else if ((cmd == CMD_MRS || cmd == CMD_REF || cmd == CMD_SREF) && any_open)
                                                                      st_d.code = V_IDLE;
        else if (is_rw && !bank_open[ba])                             st_d.code = V_CLOSED;
        else if (cmd == CMD_ACT && bank_open[ba])                     st_d.code = V_OPEN;
        else if (is_rw && rcd_b[ba])                                  st_d.code = V_RCD;
        else if (cmd == CMD_PRE && ras_hit)                           st_d.code = V_RAS;
        else if (cmd == CMD_ACT && rp_b[ba])                          st_d.code = V_RP;
        else if (cmd == CMD_ACT && rc_b[ba])                          st_d.code = V_RC;
        else if (cmd == CMD_ACT && rrd_busy)                          st_d.code = V_RRD;
        else                                                          st_d.code = V_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.burst <= CW'(2);
        end else begin
            st_q <= st_d;
        end
    end

    assign viol_code  = st_q.code;
    assign viol_valid = (st_q.code != V_NONE);

    // R3
    pre_all_chk: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_PRE && ap_a10 |=> bank_open == '0);

    // R4
    idle_rule_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_MRS || cmd == CMD_REF || cmd == CMD_SREF) && any_open
        && !mrd_busy && !rfc_busy |=> viol_code == V_IDLE);

    // R8
    rfc_window_chk: assert property (@(posedge clk) disable iff (rst)
        cmd != CMD_NONE && rfc_busy && !mrd_busy |=> viol_valid && viol_code == V_RFC);

    // R10
    cke_low_chk: assert property (@(posedge clk) disable iff (rst)
        !cke && !st_q.cke |=> !viol_valid && $stable(bank_open));

    // R1
    nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n || {ras_n, cas_n, we_n} == 3'b111) |=> !viol_valid && $stable(bank_open));

endmodule

// File: tb/tb_ddr_cmd_monitor.sv
module tb_ddr_cmd_monitor;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cke = 1'b1;
    logic       cs_n = 1'b1;
    logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic       ap_a10 = 1'b0;
    logic [2:0] addr_lo = '0;
    logic       viol_valid;
    logic [3:0] viol_code;
    logic [3:0] bank_open;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ddr_cmd_monitor dut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .ap_a10(ap_a10), .addr_lo(addr_lo),
        .viol_valid(viol_valid), .viol_code(viol_code), .bank_open(bank_open)
    );

    // {cs_n, ras/cas/we, ba, a10, addr_lo, expected code, expected bank_open}
    localparam int NV = 52;
    localparam logic [17:0] VEC [NV] = '{
        18'b0_000_00_0_011_0000_0000, //  0 R9 mode write, 8 beats
        18'b0_111_00_0_000_0000_0000, //  1 R1 nop
        18'b0_011_00_0_000_0000_0001, //  2 R8 activate at tMRD edge, R2
        18'b0_011_01_0_000_1011_0011, //  3 R7 second bank too early
        18'b0_101_00_0_000_0111_0011, //  4 R6 read before tRCD
        18'b0_101_00_0_000_0000_0011, //  5 R6 read at tRCD
        18'b0_010_00_0_000_1000_0010, //  6 R6 precharge before tRAS
        18'b0_011_00_0_000_1001_0011, //  7 R6 tRP beats tRC
        18'b0_011_00_0_000_0110_0011, //  8 R5 activate open bank
        18'b0_100_10_0_000_0101_0011, //  9 R5 write closed bank
        18'b0_111_00_0_000_0000_0011, // 10
        18'b0_001_00_0_000_0100_0011, // 11 R4 refresh while open
        18'b0_010_00_1_000_0010_0000, // 12 R8 in refresh window, R3 all close
        18'b0_111_00_0_000_0000_0000,
        18'b0_111_00_0_000_0000_0000,
        18'b0_111_00_0_000_0000_0000,
        18'b0_111_00_0_000_0000_0000,
        18'b0_111_00_0_000_0000_0000,
        18'b0_111_00_0_000_0000_0000,
        18'b0_111_00_0_000_0000_0000,
        18'b0_111_00_0_000_0000_0000,
        18'b0_111_00_0_000_0000_0000, // 21
        18'b0_110_00_0_000_0010_0000, // 22 R8 burst stop, last refresh cycle
        18'b0_011_11_0_000_0000_1000, // 23 R8 first free cycle
        18'b0_111_00_0_000_0000_1000,
        18'b0_111_00_0_000_0000_1000,
        18'b0_100_11_1_000_0000_0000, // 26 R9 write auto-precharge, R3
        18'b0_101_00_0_000_0011_0000, // 27 R9 blocked
        18'b0_111_00_0_000_0000_0000,
        18'b0_100_11_0_000_0011_0000, // 29 R9 last blocked cycle
        18'b0_100_11_0_000_0101_0000, // 30 R9 block over
        18'b0_011_11_0_000_1001_1000, // 31 R9 rp after burst
        18'b0_000_01_0_001_0100_1000, // 32 R4 extended mode write while open
        18'b0_010_00_1_000_0001_0000, // 33 R8 tMRD, R11 state still updates
        18'b0_111_00_0_000_0000_0000,
        18'b0_111_00_0_000_0000_0000,
        18'b0_011_01_0_000_0000_0010, // 36
        18'b0_011_10_0_000_1011_0110, // 37 R7
        18'b0_011_11_0_000_1010_1110, // 38 R11 tRC beats tRRD
        18'b0_111_00_0_000_0000_1110,
        18'b0_011_00_0_000_0000_1111, // 40 R7 at tRRD
        18'b0_010_00_1_000_1000_0000, // 41 R6 all-bank precharge hits tRAS
        18'b0_111_00_0_000_0000_0000,
        18'b0_111_00_0_000_0000_0000,
        18'b0_000_00_0_001_0000_0000, // 44 R9 2 beats
        18'b0_111_00_0_000_0000_0000,
        18'b0_011_10_0_000_1010_0100, // 46 R6 tRC alone
        18'b0_111_00_0_000_0000_0100,
        18'b0_111_00_0_000_0000_0100,
        18'b0_100_10_1_000_0000_0000, // 49 R9 write auto-precharge, 2 beats
        18'b0_100_10_0_000_0101_0000, // 50 R9 no block window
        18'b0_011_10_0_000_1001_0100  // 51 R9 rp after one-cycle burst
    };

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd1, 4'd2:             return "R8";
            4'd3:                   return "R9";
            4'd4:                   return "R4";
            4'd5, 4'd6:             return "R5";
            4'd7, 4'd8, 4'd9, 4'd10: return "R6";
            4'd11:                  return "R7";
            default:                return "R1";
        endcase
    endfunction

    task automatic check(input logic [3:0] ec, input logic [3:0] eo, input string tag);
        checks++;
        if (viol_code !== ec || viol_valid !== (ec != 4'd0) || bank_open !== eo) begin
            fails++;
            $display("FAIL %s: actual code=%0d valid=%0b open=%b expected code=%0d valid=%0b open=%b",
                     tag, viol_code, viol_valid, bank_open, ec, (ec != 4'd0), eo);
        end
    endtask

    task automatic step(input logic k, input logic cs, input logic [2:0] rcw,
                        input logic [1:0] b, input logic a10, input logic [2:0] lo,
                        input logic [3:0] ec, input logic [3:0] eo, input string tag);
        cke = k; cs_n = cs; {ras_n, cas_n, we_n} = rcw;
        ba = b; ap_a10 = a10; addr_lo = lo;
        @(negedge clk);
        check(ec, eo, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R11: watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        cs_n = 1'b0;
        check(4'd0, 4'b0000, "R12 reset state");

        for (int i = 0; i < NV; i++) begin
            logic [17:0] v;
            v = VEC[i];
            step(1'b1, v[17], v[16:14], v[13:12], v[11], v[10:8], v[7:4], v[3:0],
                 $sformatf("%s vector %0d", req_of(v[7:4]), i));
        end

        // R12: reset mid-sequence, bank 2 was open
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(4'd0, 4'b0000, "R12 reset clears banks and flag");
        step(1'b1, 1'b0, 3'b011, 2'd1, 1'b0, 3'b000, 4'd0, 4'b0010, "R12 first activate free");
        step(1'b1, 1'b1, 3'b000, 2'd0, 1'b0, 3'b000, 4'd0, 4'b0010, "R1 deselect ignored");
        step(1'b0, 1'b0, 3'b101, 2'd0, 1'b0, 3'b000, 4'd0, 4'b0010, "R10 cke low read ignored");
        step(1'b0, 1'b0, 3'b001, 2'd0, 1'b0, 3'b000, 4'd0, 4'b0010, "R10 cke low refresh not entry");
        step(1'b1, 1'b0, 3'b111, 2'd0, 1'b0, 3'b000, 4'd0, 4'b0010, "R1 nop");
        step(1'b0, 1'b0, 3'b001, 2'd0, 1'b0, 3'b000, 4'd4, 4'b0010, "R10 self-refresh entry while open");
        step(1'b1, 1'b0, 3'b010, 2'd1, 1'b0, 3'b000, 4'd8, 4'b0000, "R10 tRAS counted through cke low");
        step(1'b1, 1'b0, 3'b011, 2'd0, 1'b0, 3'b000, 4'd0, 4'b0001, "R2 activate bank 0");
        step(1'b1, 1'b0, 3'b111, 2'd0, 1'b0, 3'b000, 4'd0, 4'b0001, "R1 nop");
        step(1'b1, 1'b0, 3'b111, 2'd0, 1'b0, 3'b000, 4'd0, 4'b0001, "R1 nop");
        step(1'b1, 1'b0, 3'b100, 2'd0, 1'b1, 3'b000, 4'd0, 4'b0000, "R12 write auto-precharge default 4 beats");
        step(1'b1, 1'b0, 3'b100, 2'd0, 1'b0, 3'b000, 4'd3, 4'b0000, "R12 blocked one cycle");
        step(1'b1, 1'b0, 3'b100, 2'd0, 1'b0, 3'b000, 4'd5, 4'b0000, "R11 pulse ends, closed bank");
        step(1'b1, 1'b0, 3'b111, 2'd0, 1'b0, 3'b000, 4'd0, 4'b0000, "R11 pulse one cycle");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule